// File: doc/BRIEF.md
# Transfer-Controller Activation Router

This block decides, for each of N peripheral interrupt flags, whether the request starts a data transfer or goes to the CPU as an ordinary interrupt. A per-source routing register makes that choice. A bit set to 1 claims the flag as a transfer trigger. A bit cleared to 0 lets the flag reach the CPU through a global mask. Software can also start a transfer by writing a vector register with its arm bit set.

At most one activation is presented to the transfer engine at a time. It carries a source index, a vector and a software marker, and it stays fixed until the engine returns a completion pulse. The pulse comes with two qualifiers: an interrupt-request flag and a count-exhausted flag. If both are low, the block clears the trigger quietly: the peripheral gets a one-cycle flag-clear pulse, or the software arm bit drops. If either is high, the trigger is handed to the CPU instead. For a peripheral source, the routing bit drops and the flag is left standing. For software, the arm bit stays set and a software interrupt is raised.

Top module: `act_router`

## Requirements
- R1: A flag whose routing bit is 1 produces an activation and never appears on `cpu_irq`. A flag whose routing bit is 0 produces no activation and, while unmasked, appears on `cpu_irq` at its own bit position.
- R2: While `cpu_mask` is 1, every bit of `cpu_irq` and `cpu_irq_sw` is 0 from the next clock on.
- R3: When several triggers are pending, the lowest-numbered peripheral source is presented first. The software trigger has the lowest priority and is reported as source index N_SRC with `act_sw` = 1.
- R4: `act_valid`, `act_src`, `act_vec` and `act_sw` hold steady until `xfer_done` is seen. In the cycle after completion, `act_valid` is 0.
- R5: A peripheral completion with `xfer_dis` = 0 and `xfer_last` = 0 drives a single-cycle pulse on the matching bit of `flag_clr`, leaves the routing register unchanged and raises no CPU interrupt.
- R6: A peripheral completion with `xfer_dis` = 1 or `xfer_last` = 1 clears the matching routing bit and drives no `flag_clr` pulse. The still-standing flag then shows on `cpu_irq`.
- R7: A software completion with both qualifiers at 0 clears the software arm bit (`sw_en_rd` = 0) and raises no `cpu_irq_sw`.
- R8: A software completion with either qualifier at 1 keeps `sw_en_rd` at 1 and raises `cpu_irq_sw` until the next software write. No further software activation starts in that time.
- R9: A write to the routing register while a transfer is active does not change the presented activation or how its completion is handled. It takes effect at the next arbitration.
- R10: The vector of peripheral source i is VEC_BASE + i. The vector of a software activation is the value last written to `sw_wvec`.
- R11: After reset there is no activation and no clear pulse, the routing register and software arm bit are 0, and no CPU interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | N_SRC | Peripheral interrupt flags (level) |
| en_wr | input | 1 | Routing register write strobe |
| en_wdata | input | N_SRC | Routing register write data |
| en_rd | output | N_SRC | Routing register contents |
| sw_wr | input | 1 | Software vector register write strobe |
| sw_wvec | input | VEC_W | Software vector written |
| sw_wen | input | 1 | Software arm bit written |
| sw_en_rd | output | 1 | Software arm bit contents |
| cpu_mask | input | 1 | Global CPU interrupt mask, 1 = masked |
| cpu_irq | output | N_SRC | Per-source CPU interrupt requests |
| cpu_irq_sw | output | 1 | Software-activation CPU interrupt |
| act_valid | output | 1 | An activation is presented |
| act_src | output | SRC_W | Source index; N_SRC means software |
| act_vec | output | VEC_W | Vector of the presented activation |
| act_sw | output | 1 | Presented activation is a software one |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| xfer_dis | input | 1 | Completion qualifier: pass interrupt to CPU |
| xfer_last | input | 1 | Completion qualifier: transfer count exhausted |
| flag_clr | output | N_SRC | Single-cycle peripheral flag-clear pulses |

## Verification
The assertions assume that `xfer_done` is a single-cycle pulse given only while `act_valid` is high. They also assume that a software write never falls in the same cycle as a software completion, and that a peripheral holds its flag until a `flag_clr` pulse or its own clear. The bench keeps within these limits in three ways. Its transfer-engine task raises `xfer_done` only after it has seen `act_valid`. Its software writes happen only while no software activation is in flight. Its peripheral model clears a flag only on a `flag_clr` pulse or on an explicit clear from the bench. A scoreboard queue holds the expected order of activations. Any activation that is not in the queue, such as a software trigger that restarts after an interrupt hand-off, counts as a miscompare.

// File: rtl/act_router_pkg.sv
package act_router_pkg;

  // Completion qualifiers returned by the transfer engine.
  typedef struct packed {
    logic dis;   // request that the CPU be interrupted
    logic last;  // transfer count has run out
  } cmp_info_t;

  // Completion hands the trigger to the CPU when either qualifier is set.
  function automatic logic hand_to_cpu(input cmp_info_t c);
    return c.dis | c.last;
  endfunction

endpackage

// File: rtl/act_prio_arb.sv
module act_prio_arb #(
  parameter int N_REQ = 9,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  logic [N_REQ-1:0] below;  // below[i]: some lower-numbered request is active
  logic [N_REQ-1:0] gnt;

  assign below[0] = 1'b0;
  assign gnt[0]   = req[0];

  genvar gi;
  generate
    for (gi = 1; gi < N_REQ; gi++) begin : g_chain
      assign below[gi] = below[gi-1] | req[gi-1];
      assign gnt[gi]   = req[gi] & ~below[gi];
    end
  endgenerate

  assign any = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/act_sw_vec.sv
module act_sw_vec #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [VEC_W-1:0] wvec,
  input  logic             wen,
  input  logic             cmp,      // software transfer completed
  input  logic             cmp_cpu,  // completion hands off to CPU
  output logic [VEC_W-1:0] vec,
  output logic             en,
  output logic             pend,     // CPU interrupt owed for software
  output logic             ready     // software trigger may be arbitrated
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec  <= '0;
      en   <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (cmp) begin
        if (cmp_cpu) pend <= 1'b1;
        else         en   <= 1'b0;
      end
      if (wr) begin
        vec  <= wvec;
        en   <= wen;
        pend <= 1'b0;
      end
    end
  end

  assign ready = en & ~pend;

  // R7: quiet completion drops the arm bit
  a_r7_sw_disarm: assert property (@(posedge clk) disable iff (rst)
    (cmp && !cmp_cpu && !wr) |=> !en);

  // R8: hand-off keeps the arm bit and owes the CPU an interrupt
  a_r8_sw_keep: assert property (@(posedge clk) disable iff (rst)
    (cmp && cmp_cpu && !wr) |=> (en == $past(en)) && pend && !ready);

endmodule

// File: rtl/act_router.sv
module act_router
  import act_router_pkg::*;
#(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  localparam int SRC_W   = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_flag,
  input  logic             en_wr,
  input  logic [N_SRC-1:0] en_wdata,
  output logic [N_SRC-1:0] en_rd,
  input  logic             sw_wr,
  input  logic [VEC_W-1:0] sw_wvec,
  input  logic             sw_wen,
  output logic             sw_en_rd,
  input  logic             cpu_mask,
  output logic [N_SRC-1:0] cpu_irq,
  output logic             cpu_irq_sw,
  output logic             act_valid,
  output logic [SRC_W-1:0] act_src,
  output logic [VEC_W-1:0] act_vec,
  output logic             act_sw,
  input  logic             xfer_done,
  input  logic             xfer_dis,
  input  logic             xfer_last,
  output logic [N_SRC-1:0] flag_clr
);

  localparam int N_REQ = N_SRC + 1;  // software request sits at the top index

  logic [N_SRC-1:0] en_q, en_n;
  logic [N_SRC-1:0] clr_q, irq_q;
  logic             irq_sw_q;
  logic             busy_q, cool_q, cur_sw_q;
  logic [SRC_W-1:0] cur_src_q;
  logic [VEC_W-1:0] cur_vec_q;

  logic [VEC_W-1:0] sw_vec;
  logic             sw_en, sw_pend, sw_ready;
  logic [N_REQ-1:0] req;
  logic             arb_any;
  logic [SRC_W-1:0] arb_idx;
  logic             grant, done_ok, int_cmp, sw_cmp, to_cpu;
  cmp_info_t        cinfo;

  assign cinfo   = '{dis: xfer_dis, last: xfer_last};
  assign to_cpu  = hand_to_cpu(cinfo);
  assign done_ok = busy_q & xfer_done;
  assign int_cmp = done_ok & ~cur_sw_q;
  assign sw_cmp  = done_ok & cur_sw_q;

  act_sw_vec #(.VEC_W(VEC_W)) u_sw (
    .clk(clk), .rst(rst),
    .wr(sw_wr), .wvec(sw_wvec), .wen(sw_wen),
    .cmp(sw_cmp), .cmp_cpu(to_cpu),
    .vec(sw_vec), .en(sw_en), .pend(sw_pend), .ready(sw_ready)
  );

  assign req = {sw_ready, src_flag & en_q};

  act_prio_arb #(.N_REQ(N_REQ)) u_arb (
    .req(req), .any(arb_any), .idx(arb_idx)
  );

  // One idle cycle after each completion lets the peripheral drop its flag.
  assign grant = ~busy_q & ~cool_q & arb_any;

  // Routing register: software write first, completion hand-off clear wins.
  always_comb begin
    en_n = en_wr ? en_wdata : en_q;
    if (int_cmp && to_cpu) en_n[cur_src_q] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      clr_q     <= '0;
      irq_q     <= '0;
      irq_sw_q  <= 1'b0;
      busy_q    <= 1'b0;
      cool_q    <= 1'b0;
      cur_sw_q  <= 1'b0;
      cur_src_q <= '0;
      cur_vec_q <= '0;
    end else begin
      en_q     <= en_n;
      irq_q    <= src_flag & ~en_q & {N_SRC{~cpu_mask}};
      irq_sw_q <= sw_pend & ~cpu_mask;
      clr_q    <= '0;
      cool_q   <= 1'b0;
      if (done_ok) begin
        busy_q <= 1'b0;
        cool_q <= 1'b1;
        if (int_cmp && !to_cpu) clr_q <= N_SRC'(1) << cur_src_q;
      end else if (grant) begin
        busy_q    <= 1'b1;
        cur_src_q <= arb_idx;
        cur_sw_q  <= (arb_idx == SRC_W'(N_SRC));
        cur_vec_q <= (arb_idx == SRC_W'(N_SRC)) ? sw_vec
                                                 : VEC_W'(VEC_BASE) + VEC_W'(arb_idx);
      end
    end
  end

  assign en_rd      = en_q;
  assign sw_en_rd   = sw_en;
  assign cpu_irq    = irq_q;
  assign cpu_irq_sw = irq_sw_q;
  assign act_valid  = busy_q;
  assign act_src    = cur_src_q;
  assign act_vec    = cur_vec_q;
  assign act_sw     = cur_sw_q;
  assign flag_clr   = clr_q;

  // R2: masked CPU path stays silent
  a_r2_mask: assert property (@(posedge clk) disable iff (rst)
    cpu_mask |=> (cpu_irq == '0) && !cpu_irq_sw);

  // R3: the granted index is active and no lower-numbered request is
  a_r3_lowest: assert property (@(posedge clk) disable iff (rst)
    grant |-> req[arb_idx] && ((req & ((N_REQ'(1) << arb_idx) - N_REQ'(1))) == '0));

  // R4: presented activation is frozen until completion
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (act_valid && !xfer_done) |=> act_valid && $stable(act_src)
                                   && $stable(act_vec) && $stable(act_sw));

  // R4: a gap cycle follows each completion
  a_r4_gap: assert property (@(posedge clk) disable iff (rst)
    (act_valid && xfer_done) |=> !act_valid);

  // R5: flag clears are one-hot single-cycle pulses
  a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
    (flag_clr != '0) |-> $onehot0(flag_clr) ##1 (flag_clr == '0));

  // R6: hand-off completion drops the routing bit and sends no clear
  a_r6_handoff: assert property (@(posedge clk) disable iff (rst)
    (int_cmp && to_cpu) |=> (en_rd[$past(act_src)] == 1'b0) && (flag_clr == '0));

endmodule

// File: tb/sim_act_router.sv
`timescale 1ns/1ps
module sim_act_router;

  localparam int N  = 8;
  localparam int VW = 8;
  localparam int VB = 64;
  localparam int SW = $clog2(N + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst;
  logic [N-1:0]  flags, set_req, clr_req;
  logic          en_wr, sw_wr, sw_wen, cpu_mask, xfer_done, xfer_dis, xfer_last;
  logic [N-1:0]  en_wdata, en_rd, cpu_irq, flag_clr;
  logic [VW-1:0] sw_wvec, act_vec;
  logic          sw_en_rd, cpu_irq_sw, act_valid, act_sw;
  logic [SW-1:0] act_src;

  act_router #(.N_SRC(N), .VEC_W(VW), .VEC_BASE(VB)) u0 (
    .clk(clk), .rst(rst), .src_flag(flags),
    .en_wr(en_wr), .en_wdata(en_wdata), .en_rd(en_rd),
    .sw_wr(sw_wr), .sw_wvec(sw_wvec), .sw_wen(sw_wen), .sw_en_rd(sw_en_rd),
    .cpu_mask(cpu_mask), .cpu_irq(cpu_irq), .cpu_irq_sw(cpu_irq_sw),
    .act_valid(act_valid), .act_src(act_src), .act_vec(act_vec), .act_sw(act_sw),
    .xfer_done(xfer_done), .xfer_dis(xfer_dis), .xfer_last(xfer_last),
    .flag_clr(flag_clr)
  );

  // Peripheral model: flags set by the bench, cleared by pulses or the bench.
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags | set_req) & ~clr_req & ~flag_clr;
  end

  typedef struct packed {
    logic [SW-1:0] src;
    logic [VW-1:0] vec;
    logic          sw;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_err = 0, mon_chk = 0, mon_err = 0;
  logic prev_v = 1'b0;
  bit   timed_out = 0;

  // Monitor: every new activation is popped from the scoreboard and compared.
  always @(negedge clk) begin
    if (rst) prev_v = 1'b0;
    else begin
      if (act_valid && !prev_v) begin
        exp_t e;
        mon_chk++;
        if (exp_q.size() == 0) begin
          mon_err++;
          $display("FAIL R1/R8: unexpected activation src=%0d, expected none", act_src);
        end else begin
          e = exp_q.pop_front();
          if (act_src !== e.src || act_vec !== e.vec || act_sw !== e.sw) begin
            mon_err++;
            $display("FAIL R3/R10: activation src=%0d vec=%0h sw=%0b, expected src=%0d vec=%0h sw=%0b",
                     act_src, act_vec, act_sw, e.src, e.vec, e.sw);
          end
        end
      end
      prev_v = act_valid;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input int src, input int vec, input logic sw);
    exp_t e;
    e.src = SW'(src); e.vec = VW'(vec); e.sw = sw;
    exp_q.push_back(e);
  endtask

  task automatic wait_act();
    for (int k = 0; k < 40 && !act_valid; k++) @(negedge clk);
    chk("R4 activation presented", {31'd0, act_valid}, 32'd1);
  endtask

  // Transfer engine model: one completion pulse, returns one negedge later.
  task automatic finish_xfer(input logic dis, input logic last);
    xfer_done = 1'b1; xfer_dis = dis; xfer_last = last;
    @(negedge clk);
    xfer_done = 1'b0; xfer_dis = 1'b0; xfer_last = 1'b0;
  endtask

  task automatic run_all();
    rst = 1'b1;
    tick(4);
    rst = 1'b0;
    tick(1);
    // R11 reset state
    chk("R11 act_valid", {31'd0, act_valid}, 32'd0);
    chk("R11 en_rd", {24'd0, en_rd}, 32'd0);
    chk("R11 sw_en_rd", {31'd0, sw_en_rd}, 32'd0);
    chk("R11 cpu_irq", {24'd0, cpu_irq}, 32'd0);
    chk("R11 cpu_irq_sw", {31'd0, cpu_irq_sw}, 32'd0);
    chk("R11 flag_clr", {24'd0, flag_clr}, 32'd0);

    // R1: routing bit 0 sends the flag to the CPU
    set_req = 8'h04; tick(1); set_req = '0;
    tick(3);
    chk("R1 cpu route", {24'd0, cpu_irq}, 32'h04);
    chk("R1 no activation", {31'd0, act_valid}, 32'd0);
    clr_req = 8'h04; tick(1); clr_req = '0; tick(2);

    // R3/R5/R7/R10: two peripheral sources and software at once
    push(2, VB + 2, 1'b0); push(5, VB + 5, 1'b0); push(N, 8'h99, 1'b1);
    en_wr = 1'b1; en_wdata = 8'h24; sw_wr = 1'b1; sw_wvec = 8'h99; sw_wen = 1'b1;
    set_req = 8'h24;
    tick(1);
    en_wr = 1'b0; sw_wr = 1'b0; set_req = '0;
    wait_act();
    chk("R1 enabled flags kept off CPU", {24'd0, cpu_irq}, 32'd0);
    tick(3);
    chk("R4 held source", {28'd0, act_src}, 32'd2);
    finish_xfer(1'b0, 1'b0);
    chk("R4 gap after done", {31'd0, act_valid}, 32'd0);
    chk("R5 clear pulse src2", {24'd0, flag_clr}, 32'h04);
    chk("R5 routing unchanged", {24'd0, en_rd}, 32'h24);
    tick(1);
    chk("R5 pulse one cycle", {24'd0, flag_clr}, 32'd0);
    wait_act();
    finish_xfer(1'b0, 1'b0);
    chk("R5 clear pulse src5", {24'd0, flag_clr}, 32'h20);
    wait_act();
    chk("R3 software last", {31'd0, act_sw}, 32'd1);
    finish_xfer(1'b0, 1'b0);
    chk("R7 arm bit cleared", {31'd0, sw_en_rd}, 32'd0);
    tick(3);
    chk("R7 no sw interrupt", {31'd0, cpu_irq_sw}, 32'd0);
    chk("R5 no cpu interrupt", {24'd0, cpu_irq}, 32'd0);

    // R6: hand-off by disable-interrupt, then by count exhaustion
    push(3, VB + 3, 1'b0);
    en_wr = 1'b1; en_wdata = 8'h08; set_req = 8'h08;
    tick(1);
    en_wr = 1'b0; set_req = '0;
    wait_act();
    finish_xfer(1'b1, 1'b0);
    chk("R6 routing bit dropped", {24'd0, en_rd}, 32'd0);
    chk("R6 no clear pulse", {24'd0, flag_clr}, 32'd0);
    tick(2);
    chk("R6 flag to cpu", {24'd0, cpu_irq}, 32'h08);
    push(5, VB + 5, 1'b0);
    en_wr = 1'b1; en_wdata = 8'h20; set_req = 8'h20; clr_req = 8'h08;
    tick(1);
    en_wr = 1'b0; set_req = '0; clr_req = '0;
    wait_act();
    finish_xfer(1'b0, 1'b1);
    chk("R6 last drops routing", {24'd0, en_rd}, 32'd0);
    tick(2);
    chk("R6 last flag to cpu", {24'd0, cpu_irq}, 32'h20);
    cpu_mask = 1'b1; tick(2);
    chk("R2 mask blocks cpu_irq", {24'd0, cpu_irq}, 32'd0);
    cpu_mask = 1'b0; tick(2);
    chk("R2 unmask restores", {24'd0, cpu_irq}, 32'h20);
    clr_req = 8'h20; tick(1); clr_req = '0; tick(2);

    // R8: software hand-off
    push(N, 8'h77, 1'b1);
    sw_wr = 1'b1; sw_wvec = 8'h77; sw_wen = 1'b1;
    tick(1);
    sw_wr = 1'b0;
    wait_act();
    finish_xfer(1'b1, 1'b0);
    chk("R8 arm bit kept", {31'd0, sw_en_rd}, 32'd1);
    tick(2);
    chk("R8 sw interrupt", {31'd0, cpu_irq_sw}, 32'd1);
    tick(6);
    chk("R8 no restart", {31'd0, act_valid}, 32'd0);
    cpu_mask = 1'b1; tick(2);
    chk("R2 mask blocks sw interrupt", {31'd0, cpu_irq_sw}, 32'd0);
    cpu_mask = 1'b0;
    sw_wr = 1'b1; sw_wen = 1'b0; sw_wvec = 8'h00;
    tick(1);
    sw_wr = 1'b0; tick(2);
    chk("R8 write retires interrupt", {31'd0, cpu_irq_sw}, 32'd0);

    // R9: routing write during an active transfer
    push(1, VB + 1, 1'b0);
    en_wr = 1'b1; en_wdata = 8'h02; set_req = 8'h02;
    tick(1);
    en_wr = 1'b0; set_req = '0;
    wait_act();
    en_wr = 1'b1; en_wdata = 8'h00;
    tick(1);
    en_wr = 1'b0;
    tick(2);
    chk("R9 activation kept", {28'd0, act_src}, 32'd1);
    chk("R9 routing written", {24'd0, en_rd}, 32'd0);
    finish_xfer(1'b0, 1'b0);
    chk("R9 completion handled as routed", {24'd0, flag_clr}, 32'h02);
    tick(3);
    set_req = 8'h02; tick(1); set_req = '0;
    tick(3);
    chk("R9 next request to cpu", {24'd0, cpu_irq}, 32'h02);
    chk("R9 no new activation", {31'd0, act_valid}, 32'd0);
    clr_req = 8'h02; tick(1); clr_req = '0; tick(2);

    chk("R3 scoreboard drained", exp_q.size(), 32'd0);
  endtask

  initial begin
    rst = 1'b1; set_req = '0; clr_req = '0;
    en_wr = 1'b0; en_wdata = '0; sw_wr = 1'b0; sw_wvec = '0; sw_wen = 1'b0;
    cpu_mask = 1'b0; xfer_done = 1'b0; xfer_dis = 1'b0; xfer_last = 1'b0;
    fork
      run_all();
      begin
        #(5.0 * 100000);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + mon_chk, n_err + mon_err);
    $finish;
  end

endmodule